// File: doc/BRIEF.md
# Single-Precision Floating-Point Adder/Subtractor

This block adds or subtracts two IEEE-754 binary floating-point operands. The default format is single precision: sign in bit 31, biased exponent in bits 30:23 and fraction in bits 22:0. The exponent and fraction widths are parameters. When `sub` is high, the sign of operand B is inverted and the same addition datapath runs, so subtraction needs no separate hardware.

The unit restores the hidden leading one, lines up the two significands by their exponent difference and adds or subtracts them according to the effective signs. It then renormalises the result, either one place right after a carry or as many places left as needed after cancellation. Rounding is toward zero. Not-a-number inputs produce one canonical quiet NaN, and infinities pass through.

The unit is a three-stage pipeline that accepts a new operation on every cycle. A host pulses `start` with the operands and reads `result` in the cycle where `done` is high.

Top module: `fp_addsub`

## Requirements
- R1: With `sub`=0 and finite operands, `result` is the exact sum A+B truncated toward zero, whenever its magnitude lies in the normal range (for example 0x3F800000 + 0x3F800000 = 0x40000000).
- R2: With `sub`=1, `result` equals the R1 result for A and B with bit 31 of B inverted (for example 0x40400000 - 0x3F800000 = 0x40000000).
- R3: A nonzero result takes the sign of the operand with the larger magnitude. A result that is exactly zero is +0 (0x00000000), whatever the operand signs.
- R4: When the exponent difference is larger than the significand, the smaller operand still affects the truncated result exactly: 0x3F800000 + 0x30800000 = 0x3F800000, and 0x3F800000 - 0x30800000 = 0x3F7FFFFF.
- R5: A carry out of the significand shifts the result right by one and increments the exponent (0x3FC00000 + 0x3FC00000 = 0x40400000). If the exponent reaches all ones, the result saturates to the largest finite value of that sign (0x7F7FFFFF + 0x7F7FFFFF = 0x7F7FFFFF).
- R6: Subnormal inputs are used with a hidden zero and an exponent of one. After cancellation the result is shifted left until its leading one sits in the hidden position. A result whose magnitude is below the smallest normal number is flushed to +0 (0x00800001 - 0x00800000 = 0x00000000, while 0x00400000 + 0x00400000 = 0x00800000).
- R7: If either input is a NaN (exponent all ones, fraction nonzero), or the effective operation adds infinities of opposite sign, `result` is 0x7FC00000.
- R8: An infinity combined with a finite value, or with an infinity of the same effective sign, gives that infinity with its effective sign (0x3F800000 - 0x7F800000 = 0xFF800000).
- R9: If `start` is high in cycle n, `done` is high in cycle n+3, one cycle for each start, and `result` holds that operation's value in that cycle. Starts may come in consecutive cycles.
- R10: While `rst_n` is low at a clock edge, the pipeline is cleared. After the edge, `done` is 0 and `result` is 0x00000000, and any `start` seen during reset produces no `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin an operation on the operands presented this cycle |
| sub | input | 1 | 1 selects A-B, 0 selects A+B |
| op_a | input | EXP_W+MAN_W+1 (32) | Operand A |
| op_b | input | EXP_W+MAN_W+1 (32) | Operand B |
| result | output | EXP_W+MAN_W+1 (32) | Sum or difference, valid while done is high |
| done | output | 1 | One-cycle pulse marking a valid result |

## Verification
The two functions that can land in the same output cycle are the special-value override (NaN or infinity) and the finite normaliser with its saturate and flush decisions. The datapath still produces a sum from the all-ones exponents of special operands, so the override has to win over whatever the normaliser produces. This is provoked by a sweep over every operand pair and both operations of an 8-bit format (4-bit exponent, 3-bit fraction), issued back to back. Each output cycle therefore follows a different class of operation, and special results sit next to overflowing, flushed and cancelled ones. The bench judges every output against an exact integer model of the two operand values, truncated toward zero. Directed single-precision cases, issued with and without gaps, cover the default widths and the spacing of `done`.

// File: rtl/fpas_pkg.sv
`timescale 1ns/1ps
// Package fpas_pkg
// Shared types for the floating-point add/subtract pipeline.
// Assumes nothing beyond IEEE-754 binary formats with a parameterised width.
package fpas_pkg;

    // Special-value class that travels down the pipeline beside the datapath
    typedef enum logic [1:0] {
        SPC_NONE = 2'd0,
        SPC_INF  = 2'd1,
        SPC_NAN  = 2'd2
    } spc_e;

endpackage

// File: rtl/fpas_unpack.sv
`timescale 1ns/1ps
// Module fpas_unpack (pipeline stage 1)
// Splits both operands into fields, applies the subtract sign flip to B,
// restores the hidden bit (zero for subnormals, whose exponent counts as 1),
// orders the operands by magnitude and registers the exponent difference.
// Assumes: operand magnitudes compare correctly as unsigned integers of the
// exponent and fraction bits, as IEEE-754 encodings guarantee.
module fpas_unpack #(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start_i,
    input  logic                   sub_i,
    input  logic [EXP_W+MAN_W:0]   a_i,
    input  logic [EXP_W+MAN_W:0]   b_i,
    output logic                   v_o,
    output logic [EXP_W-1:0]       big_exp_o,
    output logic [MAN_W:0]         big_sig_o,
    output logic [MAN_W:0]         sml_sig_o,
    output logic [EXP_W-1:0]       diff_o,
    output logic                   eff_sub_o,
    output logic                   sign_o,
    output fpas_pkg::spc_e         spc_o,
    output logic                   spc_sign_o
);
    import fpas_pkg::*;

    localparam int W     = EXP_W + MAN_W + 1;
    localparam int SIG_W = MAN_W + 1;

    logic               sgn_a, sgn_b;
    logic [EXP_W-1:0]   exp_a, exp_b, eeff_a, eeff_b;
    logic [MAN_W-1:0]   man_a, man_b;
    logic [SIG_W-1:0]   sig_a, sig_b;
    logic               nan_a, nan_b, inf_a, inf_b, a_ge;
    spc_e               spc_n;
    logic               spc_sign_n;

    // Field split, sign flip for subtraction and hidden-bit restore
    always_comb begin
        sgn_a  = a_i[W-1];
        sgn_b  = b_i[W-1] ^ sub_i;
        exp_a  = a_i[W-2 -: EXP_W];
        exp_b  = b_i[W-2 -: EXP_W];
        man_a  = a_i[MAN_W-1:0];
        man_b  = b_i[MAN_W-1:0];
        eeff_a = (exp_a == '0) ? EXP_W'(1) : exp_a;
        eeff_b = (exp_b == '0) ? EXP_W'(1) : exp_b;
        sig_a  = {(exp_a != '0), man_a};
        sig_b  = {(exp_b != '0), man_b};
        a_ge   = (a_i[W-2:0] >= b_i[W-2:0]);
    end

    // Classify NaN and infinity inputs and the sign an infinite result takes
    always_comb begin
        nan_a = (&exp_a) & (|man_a);
        nan_b = (&exp_b) & (|man_b);
        inf_a = (&exp_a) & ~(|man_a);
        inf_b = (&exp_b) & ~(|man_b);
        if (nan_a || nan_b || (inf_a && inf_b && (sgn_a != sgn_b)))
            spc_n = SPC_NAN;
        else if (inf_a || inf_b)
            spc_n = SPC_INF;
        else
            spc_n = SPC_NONE;
        spc_sign_n = inf_a ? sgn_a : sgn_b;
    end

    // Stage-1 register: larger operand first, 8-bit style exponent difference
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_o        <= 1'b0;
            big_exp_o  <= '0;
            big_sig_o  <= '0;
            sml_sig_o  <= '0;
            diff_o     <= '0;
            eff_sub_o  <= 1'b0;
            sign_o     <= 1'b0;
            spc_o      <= SPC_NONE;
            spc_sign_o <= 1'b0;
        end else begin
            v_o        <= start_i;
            big_exp_o  <= a_ge ? eeff_a : eeff_b;
            big_sig_o  <= a_ge ? sig_a  : sig_b;
            sml_sig_o  <= a_ge ? sig_b  : sig_a;
            diff_o     <= a_ge ? (eeff_a - eeff_b) : (eeff_b - eeff_a);
            eff_sub_o  <= sgn_a ^ sgn_b;
            sign_o     <= a_ge ? sgn_a : sgn_b;
            spc_o      <= spc_n;
            spc_sign_o <= spc_sign_n;
        end
    end

endmodule

// File: rtl/fpas_align.sv
`timescale 1ns/1ps
// Module fpas_align (pipeline stage 2)
// Right-shifts the smaller significand by the exponent difference, keeping
// guard, round and sticky positions, then adds or subtracts it from the
// larger significand. The top sum bit is the carry flag.
// Assumes: the larger operand arrives first, so a subtraction never
// goes negative.
module fpas_align #(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 v_i,
    input  logic [EXP_W-1:0]     big_exp_i,
    input  logic [MAN_W:0]       big_sig_i,
    input  logic [MAN_W:0]       sml_sig_i,
    input  logic [EXP_W-1:0]     diff_i,
    input  logic                 eff_sub_i,
    input  logic                 sign_i,
    input  fpas_pkg::spc_e       spc_i,
    input  logic                 spc_sign_i,
    output logic                 v_o,
    output logic [MAN_W+4:0]     sum_o,
    output logic [EXP_W-1:0]     big_exp_o,
    output logic                 sign_o,
    output fpas_pkg::spc_e       spc_o,
    output logic                 spc_sign_o
);
    import fpas_pkg::*;

    localparam int SIG_W = MAN_W + 1;
    localparam int EXT_W = SIG_W + 3;
    localparam int SUM_W = EXT_W + 1;

    logic [EXT_W-1:0] big_ext, sml_ext, shifted, lost_mask, algn;
    logic             far, sticky;
    logic [SUM_W-1:0] sum_n;

    // Alignment: shift the small significand, fold the dropped bits into sticky
    always_comb begin
        big_ext   = {big_sig_i, 3'b000};
        sml_ext   = {sml_sig_i, 3'b000};
        far       = (diff_i >= EXP_W'(EXT_W));
        shifted   = sml_ext >> diff_i;
        lost_mask = ~({EXT_W{1'b1}} << diff_i);
        sticky    = far ? (|sml_sig_i) : (|(sml_ext & lost_mask));
        algn      = far ? {{(EXT_W-1){1'b0}}, sticky}
                        : {shifted[EXT_W-1:1], shifted[0] | sticky};
    end

    // Significand add or subtract selected by the effective signs
    always_comb begin
        if (eff_sub_i)
            sum_n = {1'b0, big_ext} - {1'b0, algn};
        else
            sum_n = {1'b0, big_ext} + {1'b0, algn};
    end

    // Stage-2 register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_o        <= 1'b0;
            sum_o      <= '0;
            big_exp_o  <= '0;
            sign_o     <= 1'b0;
            spc_o      <= SPC_NONE;
            spc_sign_o <= 1'b0;
        end else begin
            v_o        <= v_i;
            sum_o      <= sum_n;
            big_exp_o  <= big_exp_i;
            sign_o     <= sign_i;
            spc_o      <= spc_i;
            spc_sign_o <= spc_sign_i;
        end
    end

    // R3: the operand ordered as larger really is at least the aligned smaller one
    mag_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (v_i && eff_sub_i && (spc_i == SPC_NONE)) |-> (big_ext >= algn));

endmodule

// File: rtl/fpas_norm.sv
`timescale 1ns/1ps
// Module fpas_norm (pipeline stage 3)
// Renormalises the raw sum: one place right on carry, or left by the
// leading-zero count after cancellation. Truncates toward zero, saturates
// on overflow, flushes results below the normal range to +0, and lets NaN
// and infinity classes override the datapath value.
// Assumes: the sum carries guard, round and sticky bits below the fraction.
module fpas_norm #(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   v_i,
    input  logic [MAN_W+4:0]       sum_i,
    input  logic [EXP_W-1:0]       big_exp_i,
    input  logic                   sign_i,
    input  fpas_pkg::spc_e         spc_i,
    input  logic                   spc_sign_i,
    output logic [EXP_W+MAN_W:0]   res_o,
    output logic                   done_o
);
    import fpas_pkg::*;

    localparam int W     = EXP_W + MAN_W + 1;
    localparam int SIG_W = MAN_W + 1;
    localparam int EXT_W = SIG_W + 3;
    localparam int LZ_W  = $clog2(EXT_W + 1);
    localparam logic [W-1:0] CANON_NAN =
        {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

    logic [LZ_W-1:0]  lz;
    logic [EXP_W:0]   lz_x, exp_dn_x;
    logic [EXP_W-1:0] exp_up;
    logic [MAN_W-1:0] mant_c, mant_l;
    logic             carry, zero, flush;
    logic [W-1:0]     res_n;

    // Leading-zero count below the carry bit; the highest set bit wins
    always_comb begin
        lz = LZ_W'(EXT_W);
        for (int i = 0; i < EXT_W; i++) begin
            if (sum_i[i]) lz = LZ_W'(EXT_W - 1 - i);
        end
    end

    // Both renormalisation directions and their exponents
    always_comb begin
        carry    = sum_i[EXT_W];
        zero     = ~(|sum_i);
        exp_up   = big_exp_i + EXP_W'(1);
        mant_c   = sum_i[EXT_W-1 -: MAN_W];
        lz_x     = (EXP_W+1)'(lz);
        exp_dn_x = {1'b0, big_exp_i} - lz_x;
        flush    = exp_dn_x[EXP_W] | (exp_dn_x == '0);
        mant_l   = MAN_W'((sum_i[EXT_W-1:0] << lz) >> 3);
    end

    // Final selection: specials, zero, overflow, flush, then the normal cases
    always_comb begin
        if (spc_i == SPC_NAN)
            res_n = CANON_NAN;
        else if (spc_i == SPC_INF)
            res_n = {spc_sign_i, {EXP_W{1'b1}}, {MAN_W{1'b0}}};
        else if (zero)
            res_n = '0;
        else if (carry && (&exp_up))
            res_n = {sign_i, {(EXP_W-1){1'b1}}, 1'b0, {MAN_W{1'b1}}};
        else if (carry)
            res_n = {sign_i, exp_up, mant_c};
        else if (flush)
            res_n = '0;
        else
            res_n = {sign_i, exp_dn_x[EXP_W-1:0], mant_l};
    end

    // Output register and done pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_o  <= '0;
            done_o <= 1'b0;
        end else begin
            done_o <= v_i;
            if (v_i) res_o <= res_n;
        end
    end

    // R7
    nan_canon_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (v_i && (spc_i == SPC_NAN)) |=> (res_o == CANON_NAN));

    // R5
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (v_i && (spc_i == SPC_NONE)) |=> (res_o[W-2 -: EXP_W] != {EXP_W{1'b1}}));

    // R3
    zero_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && (res_o[W-2:0] == '0)) |-> !res_o[W-1]);

endmodule

// File: rtl/fp_addsub.sv
`timescale 1ns/1ps
// Module fp_addsub (top)
// Three-stage floating-point add/subtract: unpack and order, align and
// add, normalise and pack. A new operation may start every cycle; done
// follows start by three cycles.
// Assumes: operands use IEEE-754 binary layout of the given widths.
module fp_addsub #(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 sub,
    input  logic [EXP_W+MAN_W:0] op_a,
    input  logic [EXP_W+MAN_W:0] op_b,
    output logic [EXP_W+MAN_W:0] result,
    output logic                 done
);
    import fpas_pkg::*;

    logic               s1_v, s1_eff_sub, s1_sign, s1_spc_sign;
    logic [EXP_W-1:0]   s1_big_exp, s1_diff;
    logic [MAN_W:0]     s1_big_sig, s1_sml_sig;
    spc_e               s1_spc;

    logic               s2_v, s2_sign, s2_spc_sign;
    logic [MAN_W+4:0]   s2_sum;
    logic [EXP_W-1:0]   s2_big_exp;
    spc_e               s2_spc;

    // Stage 1: field split, sign flip, magnitude order, exponent difference
    fpas_unpack #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_unpack (
        .clk(clk), .rst_n(rst_n), .start_i(start), .sub_i(sub),
        .a_i(op_a), .b_i(op_b),
        .v_o(s1_v), .big_exp_o(s1_big_exp), .big_sig_o(s1_big_sig),
        .sml_sig_o(s1_sml_sig), .diff_o(s1_diff), .eff_sub_o(s1_eff_sub),
        .sign_o(s1_sign), .spc_o(s1_spc), .spc_sign_o(s1_spc_sign)
    );

    // Stage 2: alignment shift and significand add/subtract
    fpas_align #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_align (
        .clk(clk), .rst_n(rst_n), .v_i(s1_v), .big_exp_i(s1_big_exp),
        .big_sig_i(s1_big_sig), .sml_sig_i(s1_sml_sig), .diff_i(s1_diff),
        .eff_sub_i(s1_eff_sub), .sign_i(s1_sign), .spc_i(s1_spc),
        .spc_sign_i(s1_spc_sign),
        .v_o(s2_v), .sum_o(s2_sum), .big_exp_o(s2_big_exp),
        .sign_o(s2_sign), .spc_o(s2_spc), .spc_sign_o(s2_spc_sign)
    );

    // Stage 3: renormalise, truncate, saturate or flush, pack
    fpas_norm #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_norm (
        .clk(clk), .rst_n(rst_n), .v_i(s2_v), .sum_i(s2_sum),
        .big_exp_i(s2_big_exp), .sign_i(s2_sign), .spc_i(s2_spc),
        .spc_sign_i(s2_spc_sign), .res_o(result), .done_o(done)
    );

    // R9
    done_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(start, 3));

endmodule

// File: tb/fp_addsub_bench.sv
`timescale 1ns/1ps
// Bench for fp_addsub: directed single-precision cases, then an exhaustive
// sweep of an 8-bit format (4-bit exponent, 3-bit fraction) against an
// exact integer model truncated toward zero.
module fp_addsub_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        s_start = 1'b0, s_sub = 1'b0;
    logic [31:0] s_a = '0, s_b = '0, s_res;
    logic        s_done;
    logic        t_start = 1'b0, t_sub = 1'b0;
    logic [7:0]  t_a = '0, t_b = '0, t_res;
    logic        t_done;

    int checks = 0;
    int fails  = 0;
    bit fin    = 1'b0;

    logic        sp_v [1:3];
    logic [31:0] sp_r [1:3];
    string       sp_t [1:3];
    logic        tp_v [1:3];
    logic [7:0]  tp_r [1:3];
    string       tp_t [1:3];

    always #5 clk = ~clk;

    fp_addsub u_fp_addsub (
        .clk(clk), .rst_n(rst_n), .start(s_start), .sub(s_sub),
        .op_a(s_a), .op_b(s_b), .result(s_res), .done(s_done)
    );

    fp_addsub #(.EXP_W(4), .MAN_W(3)) u_fp_addsub_tiny (
        .clk(clk), .rst_n(rst_n), .start(t_start), .sub(t_sub),
        .op_a(t_a), .op_b(t_b), .result(t_res), .done(t_done)
    );

    // Value of a finite 8-bit operand in units of 2^-9
    function automatic int tiny_val(input logic [7:0] x);
        int e, m;
        e = int'(x[6:3]);
        m = int'(x[2:0]);
        if (e == 0) return m;
        return (8 + m) << (e - 1);
    endfunction

    // Exact reference for the 8-bit format, with the requirement it exercises
    function automatic logic [7:0] tiny_ref(input logic [7:0] a, input logic [7:0] b,
                                            input logic sub, output string tag);
        logic [7:0] bb;
        logic an, bn, ai, bi, sg;
        int va, vb, s, mag, p, e, ea, eb;
        bb = {b[7] ^ sub, b[6:0]};
        an = (a[6:3] == 4'hF) && (a[2:0] != 0);
        bn = (bb[6:3] == 4'hF) && (bb[2:0] != 0);
        ai = (a[6:3] == 4'hF) && (a[2:0] == 0);
        bi = (bb[6:3] == 4'hF) && (bb[2:0] == 0);
        if (an || bn) begin tag = "R7"; return 8'h7C; end
        if (ai && bi) begin
            if (a[7] != bb[7]) begin tag = "R7"; return 8'h7C; end
            tag = "R8"; return a;
        end
        if (ai) begin tag = "R8"; return a; end
        if (bi) begin tag = "R8"; return bb; end
        va = a[7]  ? -tiny_val(a)  : tiny_val(a);
        vb = bb[7] ? -tiny_val(bb) : tiny_val(bb);
        s  = va + vb;
        if (s == 0) begin tag = "R3"; return 8'h00; end
        sg  = (s < 0);
        mag = sg ? -s : s;
        p = 0;
        for (int k = 0; k < 24; k++) if (((mag >> k) & 1) != 0) p = k;
        if (p < 3) begin tag = "R6"; return 8'h00; end
        e = p - 2;
        if (e >= 15) begin tag = "R5"; return {sg, 4'hE, 3'h7}; end
        ea = (a[6:3] == 0) ? 1 : int'(a[6:3]);
        eb = (bb[6:3] == 0) ? 1 : int'(bb[6:3]);
        if ((ea - eb >= 4) || (eb - ea >= 4)) tag = "R4";
        else tag = sub ? "R2" : "R1";
        return {sg, e[3:0], mag[p-1 -: 3]};
    endfunction

    // One compare of done and result against the expectation
    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv,
                       input logic dact, input logic dexp);
        checks++;
        if ((dact !== dexp) || (dexp && (act !== expv))) begin
            fails++;
            $display("FAIL %s actual done=%0b result=%h expected done=%0b result=%h",
                     tag, dact, act, dexp, expv);
        end
    endtask

    // Advance one cycle: check outputs due now, shift expectations, drive new inputs
    task automatic step(input logic si, input logic [31:0] sa, input logic [31:0] sb,
                        input logic ssub, input logic [31:0] sexp, input string stag,
                        input logic ti, input logic [7:0] ta, input logic [7:0] tb,
                        input logic tsub, input logic [7:0] texp, input string ttag);
        @(negedge clk);
        chk(sp_v[3] ? sp_t[3] : "R9", s_res, sp_r[3], s_done, sp_v[3]);
        chk(tp_v[3] ? tp_t[3] : "R9", {24'h0, t_res}, {24'h0, tp_r[3]}, t_done, tp_v[3]);
        for (int k = 3; k > 1; k--) begin
            sp_v[k] = sp_v[k-1]; sp_r[k] = sp_r[k-1]; sp_t[k] = sp_t[k-1];
            tp_v[k] = tp_v[k-1]; tp_r[k] = tp_r[k-1]; tp_t[k] = tp_t[k-1];
        end
        sp_v[1] = si; sp_r[1] = sexp; sp_t[1] = stag;
        tp_v[1] = ti; tp_r[1] = texp; tp_t[1] = ttag;
        s_start = si; s_a = sa; s_b = sb; s_sub = ssub;
        t_start = ti; t_a = ta; t_b = tb; t_sub = tsub;
    endtask

    task automatic sop(input logic [31:0] a, input logic [31:0] b, input logic sub,
                       input logic [31:0] expv, input string tag);
        step(1'b1, a, b, sub, expv, tag, 1'b0, 8'h0, 8'h0, 1'b0, 8'h0, "R9");
    endtask

    task automatic idle();
        step(1'b0, 32'h0, 32'h0, 1'b0, 32'h0, "R9", 1'b0, 8'h0, 8'h0, 1'b0, 8'h0, "R9");
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (190000) @(posedge clk);
        if (!fin) begin
            fails++;
            $display("FAIL R9 watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int k = 1; k <= 3; k++) begin
            sp_v[k] = 1'b0; sp_r[k] = '0; sp_t[k] = "R9";
            tp_v[k] = 1'b0; tp_r[k] = '0; tp_t[k] = "R9";
        end
        // R10: starts during reset must leave no trace
        s_start = 1'b1; s_a = 32'h3F800000; s_b = 32'h3F800000;
        t_start = 1'b1; t_a = 8'h38; t_b = 8'h38;
        repeat (4) @(negedge clk);
        chk("R10", s_res, 32'h0, s_done, 1'b0);
        chk("R10", {24'h0, t_res}, 32'h0, t_done, 1'b0);
        s_start = 1'b0; t_start = 1'b0;
        rst_n = 1'b1;

        // Directed single-precision cases, some back to back, some spaced
        sop(32'h3F800000, 32'h3F800000, 1'b0, 32'h40000000, "R1");
        sop(32'h40400000, 32'h3F800000, 1'b1, 32'h40000000, "R2");
        sop(32'h3F800000, 32'h3F800000, 1'b1, 32'h00000000, "R3");
        idle();
        sop(32'hBF800000, 32'h40000000, 1'b0, 32'h3F800000, "R3");
        idle();
        idle();
        sop(32'hC0000000, 32'h3F800000, 1'b0, 32'hBF800000, "R3");
        sop(32'h80000000, 32'h80000000, 1'b0, 32'h00000000, "R3");
        sop(32'h3F800000, 32'h30800000, 1'b0, 32'h3F800000, "R4");
        sop(32'h3F800000, 32'h30800000, 1'b1, 32'h3F7FFFFF, "R4");
        sop(32'h3FC00000, 32'h3FC00000, 1'b0, 32'h40400000, "R5");
        sop(32'h7F7FFFFF, 32'h7F7FFFFF, 1'b0, 32'h7F7FFFFF, "R5");
        sop(32'hFF7FFFFF, 32'h7F7FFFFF, 1'b1, 32'hFF7FFFFF, "R5");
        sop(32'h00800001, 32'h00800000, 1'b1, 32'h00000000, "R6");
        sop(32'h00400000, 32'h00400000, 1'b0, 32'h00800000, "R6");
        sop(32'h3F800001, 32'h3F800000, 1'b1, 32'h34000000, "R6");
        sop(32'h7F800001, 32'h3F800000, 1'b0, 32'h7FC00000, "R7");
        sop(32'h7F800000, 32'hFF800000, 1'b0, 32'h7FC00000, "R7");
        sop(32'h7F800000, 32'h7F800000, 1'b1, 32'h7FC00000, "R7");
        sop(32'hFF800000, 32'h3F800000, 1'b0, 32'hFF800000, "R8");
        sop(32'h3F800000, 32'h7F800000, 1'b1, 32'hFF800000, "R8");
        sop(32'h7F800000, 32'h7F800000, 1'b0, 32'h7F800000, "R8");
        repeat (4) idle();

        // Exhaustive 8-bit sweep, one operation per cycle
        for (int i = 0; i < 131072; i++) begin
            logic [7:0] ta, tb, te;
            logic       ts;
            string      tg;
            ta = i[7:0];
            tb = i[15:8];
            ts = i[16];
            te = tiny_ref(ta, tb, ts, tg);
            step(1'b0, 32'h0, 32'h0, 1'b0, 32'h0, "R9", 1'b1, ta, tb, ts, te, tg);
        end
        repeat (4) idle();

        fin = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule